// File: doc/BRIEF.md
# Firmware Word Loader

This block is a register-mapped slave that takes a firmware image from a host processor one 32-bit word at a time and stores it in an internal instruction RAM. The host opens a load session by setting an enable bit, then for each word writes the word to a data register and raises a "word ready" flag in the control register with a read-modify-write. The slave holds the flag for a fixed number of cycles, stores the word at its write pointer, and drops the flag. The host polls for the drop and treats a flag that never drops as a timeout.

The host ends the session by clearing the enable bit. The slave then checks the load and raises a read-only done bit when at least one word arrived and none was lost to overflow. A separate three-bit interrupt-enable register, covering controller, power-management and system-error sources, is held here and driven out to the controller. A registered read port into the RAM lets the consuming core fetch the loaded words. The host packs image bytes little-endian and zero-fills a short final word. The slave stores each word exactly as written.

Top module: `fwdl_slave`

## Requirements
- R1: After synchronous reset every register reads zero, `int_en` is zero and `bus_rdata` is zero.
- R2: The interrupt-enable register at byte offset 0x224 stores write data bits 2:0, returns them on read with all other bits zero, and drives them on `int_en`.
- R3: The control register at offset 0x250 reads as: bit 0 enable (read/write), bit 4 done, bit 8 word-ready flag, bit 12 overflow, all other bits zero. A read returns data on `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` holds its value while `bus_rd` is low.
- R4: Writing the control register with bits 0 and 8 both set while enable is high raises the word-ready flag. The flag reads 1 on exactly ACCEPT_CYC consecutive back-to-back reads after that write, then reads 0. Only the slave clears it.
- R5: Each accepted word is written to RAM at the write pointer, which then increments. The first word of a session lands at RAM index 0. `iram_rdata` returns RAM[`iram_raddr`] one cycle later.
- R6: A control write that takes enable from 0 to 1 resets the write pointer and clears the done and overflow bits.
- R7: A word accepted when DEPTH words are already stored is dropped and sets the overflow bit. The bit stays set until the next session opens, and the stored words are unchanged.
- R8: After a control write that takes enable from 1 to 0, the done bit rises within a few cycles if at least one word was stored and overflow is clear. Otherwise it stays 0.
- R9: Host writes to the done bit and the overflow bit have no effect.
- R10: While enable is low, writes to the data register and requests to raise the word-ready flag are ignored.
- R11: The data register at offset 0x258 reads back the last word accepted into it. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| int_en | output | 3 | Interrupt enables: bit 0 controller, bit 1 power management, bit 2 system error |
| iram_raddr | input | log2(DEPTH) | Instruction RAM fetch address |
| iram_rdata | output | 32 | Instruction RAM fetch data, one cycle after the address |

## Verification
The bench builds the loader with DEPTH=8 and ACCEPT_CYC=3. The small depth lets a session run past the end of the RAM, which exercises the overflow drop and its effect on the done bit within a short run. The three-cycle acceptance window makes the count of polls that see the flag high a distinct, checkable number. Randomly sized sessions with random words and a zero-filled short final word are mixed with the empty session, the restart after an overflow, and writes made while enable is low.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;
    localparam int IEN_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_IEN  = 12'h224;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h250;
    localparam logic [ADDR_W-1:0] OFS_DATA = 12'h258;

    localparam int B_EN   = 0;
    localparam int B_DONE = 4;
    localparam int B_RDY  = 8;
    localparam int B_OVF  = 12;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_IEN,
        SEL_CTRL,
        SEL_DATA
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic done;
        logic rdy;
        logic ovf;
    } ctrl_view_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == OFS_IEN)       return SEL_IEN;
        else if (a == OFS_CTRL) return SEL_CTRL;
        else if (a == OFS_DATA) return SEL_DATA;
        else                    return SEL_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_view_t v);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[B_EN]   = v.en;
        w[B_DONE] = v.done;
        w[B_RDY]  = v.rdy;
        w[B_OVF]  = v.ovf;
        return w;
    endfunction

endpackage

// File: rtl/fwdl_regbus.sv
module fwdl_regbus
    import fwdl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic                st_done,
    input  logic                st_rdy,
    input  logic                st_ovf,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                en_q,
    output logic [WORD_W-1:0]   data_q,
    output logic [IEN_W-1:0]    ien_q,
    output logic                open_p,
    output logic                close_p,
    output logic                set_req
);

    reg_sel_e   sel;
    logic       ctrl_wr;
    ctrl_view_t view;

    assign sel     = decode_addr(bus_addr);
    assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
    assign open_p  = ctrl_wr && bus_wdata[B_EN] && !en_q;
    assign close_p = ctrl_wr && !bus_wdata[B_EN] && en_q;
    assign set_req = ctrl_wr && en_q && bus_wdata[B_EN] && bus_wdata[B_RDY] && !st_rdy;

    always_comb begin
        view.en   = en_q;
        view.done = st_done;
        view.rdy  = st_rdy;
        view.ovf  = st_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            data_q    <= '0;
            ien_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr) begin
                case (sel)
                    SEL_IEN:  ien_q <= bus_wdata[IEN_W-1:0];
                    SEL_CTRL: en_q  <= bus_wdata[B_EN];
                    SEL_DATA: if (en_q) data_q <= bus_wdata;
                    default:  ;
                endcase
            end
            if (bus_rd) begin
                case (sel)
                    SEL_IEN:  bus_rdata <= {{(WORD_W-IEN_W){1'b0}}, ien_q};
                    SEL_CTRL: bus_rdata <= pack_ctrl(view);
                    SEL_DATA: bus_rdata <= data_q;
                    default:  bus_rdata <= '0;
                endcase
            end
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R3
    AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> $stable(data_q)); // R10

endmodule

// File: rtl/fwdl_loader.sv
module fwdl_loader
    import fwdl_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int ACCEPT_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic                      open_p,
    input  logic                      close_p,
    input  logic                      set_req,
    input  logic [WORD_W-1:0]         word_in,
    output logic                      rdy,
    output logic                      done,
    output logic                      ovf,
    output logic                      we,
    output logic [$clog2(DEPTH)-1:0]  waddr,
    output logic [WORD_W-1:0]         wdat
);

    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int TW    = $clog2(ACCEPT_CYC) + 1;
    localparam logic [CW-1:0] FULL  = CW'(DEPTH);
    localparam logic [TW-1:0] TLOAD = TW'(ACCEPT_CYC - 1);

    logic [CW-1:0]     wcnt;
    logic [TW-1:0]     tmr;
    logic [WORD_W-1:0] hold;
    logic              chk_pend;
    logic              commit;

    assign commit = rdy && (tmr == '0);
    assign we     = commit && (wcnt != FULL);
    assign waddr  = wcnt[AW-1:0];
    assign wdat   = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy      <= 1'b0;
            done     <= 1'b0;
            ovf      <= 1'b0;
            wcnt     <= '0;
            tmr      <= '0;
            hold     <= '0;
            chk_pend <= 1'b0;
        end else begin
            if (set_req) begin
                rdy  <= 1'b1;
                tmr  <= TLOAD;
                hold <= word_in;
            end else if (rdy && tmr != '0) begin
                tmr <= tmr - TW'(1);
            end else if (commit) begin
                rdy <= 1'b0;
                if (wcnt == FULL) ovf  <= 1'b1;
                else              wcnt <= wcnt + CW'(1);
            end

            if (close_p) chk_pend <= 1'b1;
            if (chk_pend && !rdy) begin
                done     <= (wcnt != '0) && !ovf;
                chk_pend <= 1'b0;
            end

            if (open_p) begin
                wcnt     <= '0;
                ovf      <= 1'b0;
                done     <= 1'b0;
                chk_pend <= 1'b0;
            end
        end
    end

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> en); // R10
    AST_FLAG_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rdy && tmr == '0) |=> !rdy); // R4
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        wcnt <= FULL); // R7
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> !ovf); // R8
    AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (wcnt == '0 && !done && !ovf)); // R6

endmodule

// File: rtl/fwdl_iram.sv
module fwdl_iram
    import fwdl_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [WORD_W-1:0]         wdat,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [WORD_W-1:0]         rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdat;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= mem[raddr];
    end

    AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH)); // R5

endmodule

// File: rtl/fwdl_slave.sv
module fwdl_slave
    import fwdl_pkg::*;
#(
    parameter int DEPTH      = 1024,
    parameter int ACCEPT_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [11:0]               bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [2:0]                int_en,
    input  logic [$clog2(DEPTH)-1:0]  iram_raddr,
    output logic [31:0]               iram_rdata
);

    localparam int AW = $clog2(DEPTH);

    logic              en_q, open_p, close_p, set_req;
    logic              st_rdy, st_done, st_ovf;
    logic [WORD_W-1:0] data_q, wdat;
    logic              we;
    logic [AW-1:0]     waddr;

    fwdl_regbus u_regbus (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .st_done   (st_done),
        .st_rdy    (st_rdy),
        .st_ovf    (st_ovf),
        .bus_rdata (bus_rdata),
        .en_q      (en_q),
        .data_q    (data_q),
        .ien_q     (int_en),
        .open_p    (open_p),
        .close_p   (close_p),
        .set_req   (set_req)
    );

    fwdl_loader #(
        .DEPTH      (DEPTH),
        .ACCEPT_CYC (ACCEPT_CYC)
    ) u_loader (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .open_p  (open_p),
        .close_p (close_p),
        .set_req (set_req),
        .word_in (data_q),
        .rdy     (st_rdy),
        .done    (st_done),
        .ovf     (st_ovf),
        .we      (we),
        .waddr   (waddr),
        .wdat    (wdat)
    );

    fwdl_iram #(
        .DEPTH (DEPTH)
    ) u_iram (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdat  (wdat),
        .raddr (iram_raddr),
        .rdata (iram_rdata)
    );

endmodule

// File: tb/fwdl_slave_tb.sv
`timescale 1ns/1ps
module fwdl_slave_tb;

    localparam int DEPTH = 8;
    localparam int ACC   = 3;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [2:0]    int_en;
    logic [AW-1:0] iram_raddr = '0;
    logic [31:0]   iram_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] model [DEPTH];

    always #5 clk = ~clk;

    fwdl_slave #(.DEPTH(DEPTH), .ACCEPT_CYC(ACC)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_en(int_en), .iram_raddr(iram_raddr), .iram_rdata(iram_rdata)
    );

    function automatic logic [31:0] ctrl_word(input bit en, input bit done,
                                              input bit rdy, input bit ovf);
        return {19'd0, ovf, 3'd0, rdy, 3'd0, done, 3'd0, en};
    endfunction

    function automatic logic [31:0] tail_word(input logic [31:0] raw, input int nbytes);
        logic [31:0] m;
        m = (nbytes >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nbytes)) - 32'd1);
        return raw & m;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic iread(input int idx, output logic [31:0] d);
        iram_raddr = AW'(idx);
        @(negedge clk);
        d = iram_rdata;
    endtask

    task automatic push_word(input logic [31:0] w, input bit check_poll);
        logic [31:0] v;
        int hi;
        bwrite(12'h258, w);
        bread(12'h250, v);
        bwrite(12'h250, v | 32'h100);
        hi = 0;
        for (int i = 0; i < 50; i++) begin
            bread(12'h250, v);
            if (!v[8]) break;
            hi++;
        end
        if (check_poll)
            check(hi == ACC, "R4 flag poll count", 32'(hi), 32'(ACC));
    endtask

    task automatic close_and_wait(output logic [31:0] v);
        bwrite(12'h250, 32'h0);
        for (int i = 0; i < 6; i++) bread(12'h250, v);
    endtask

    task automatic good_session(input int n);
        logic [31:0] v, w;
        bwrite(12'h250, 32'h1);
        bread(12'h250, v);
        check(v == ctrl_word(1, 0, 0, 0), "R6 open clears status", v, ctrl_word(1, 0, 0, 0));
        for (int k = 0; k < n; k++) begin
            w = $urandom;
            if (k == n - 1) w = tail_word(w, 1 + int'($urandom % 4));
            model[k] = w;
            push_word(w, k < 2);
        end
        bread(12'h258, v);
        check(v == model[n-1], "R11 data readback", v, model[n-1]);
        close_and_wait(v);
        check(v == ctrl_word(0, 1, 0, 0), "R8 done after good load", v, ctrl_word(0, 1, 0, 0));
        for (int k = 0; k < n; k++) begin
            iread(k, w);
            check(w == model[k], "R5 stored word", w, model[k]);
        end
    endtask

    initial begin
        logic [31:0] v, w;
        process::self().srandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(bus_rdata == 0, "R1 rdata after reset", bus_rdata, 0);
        check(int_en == 0, "R1 int_en after reset", 32'(int_en), 0);
        bread(12'h250, v); check(v == 0, "R1 ctrl after reset", v, 0);
        bread(12'h224, v); check(v == 0, "R1 ien after reset", v, 0);
        bread(12'h258, v); check(v == 0, "R1 data after reset", v, 0);

        // R2 interrupt enables
        bwrite(12'h224, 32'hFFFF_FFFF);
        bread(12'h224, v); check(v == 32'h7, "R2 ien readback", v, 32'h7);
        check(int_en == 3'h7, "R2 int_en port", 32'(int_en), 32'h7);
        bwrite(12'h224, 32'h2);
        bread(12'h224, v); check(v == 32'h2, "R2 ien single bit", v, 32'h2);

        // R11 unused offsets, R3 hold
        bread(12'h100, v); check(v == 0, "R11 unused offset", v, 0);
        bread(12'h254, v); check(v == 0, "R11 gap offset", v, 0);
        @(negedge clk);
        check(bus_rdata == 0, "R3 rdata holds without read", bus_rdata, 0);

        // R10 ignored while enable low
        bwrite(12'h258, 32'hDEAD_BEEF);
        bread(12'h258, v); check(v == 0, "R10 data write ignored", v, 0);
        bwrite(12'h250, 32'h100);
        bread(12'h250, v); check(v == 0, "R10 flag request ignored", v, 0);

        // sessions with random sizes
        good_session(1);
        // R9 done not writable
        bwrite(12'h250, 32'h0);
        bread(12'h250, v); check(v == ctrl_word(0, 1, 0, 0), "R9 done survives write 0", v, ctrl_word(0, 1, 0, 0));
        good_session(1 + int'($urandom % DEPTH));
        good_session(DEPTH);

        // R7 overflow session
        bwrite(12'h250, 32'h1);
        for (int k = 0; k < DEPTH + 2; k++) begin
            w = $urandom;
            if (k < DEPTH) model[k] = w;
            push_word(w, 1'b0);
        end
        bread(12'h250, v);
        check(v == ctrl_word(1, 0, 0, 1), "R7 overflow set", v, ctrl_word(1, 0, 0, 1));
        bwrite(12'h250, 32'h1011);
        bread(12'h250, v);
        check(v == ctrl_word(1, 0, 0, 1), "R9 status bits not writable", v, ctrl_word(1, 0, 0, 1));
        close_and_wait(v);
        check(v == ctrl_word(0, 0, 0, 1), "R8 no done after overflow", v, ctrl_word(0, 0, 0, 1));
        for (int k = 0; k < DEPTH; k++) begin
            iread(k, w);
            check(w == model[k], "R7 stored words kept", w, model[k]);
        end

        // R6 reopen clears overflow; R8 empty session
        bwrite(12'h250, 32'h1);
        bread(12'h250, v); check(v == ctrl_word(1, 0, 0, 0), "R6 reopen clears ovf", v, ctrl_word(1, 0, 0, 0));
        close_and_wait(v);
        check(v == 0, "R8 empty session no done", v, 0);

        // R5 pointer restarts at zero
        good_session(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule